// File: doc/BRIEF.md
# SMM Top-Segment Access Filter

This block sits in a memory controller's address-decode path. It finds the base of the protected system-management segment at the top of low memory. It then decides, for each incoming request, whether the request may reach DRAM unchanged. The segment sits directly below the graphics stolen memory, and that stolen memory ends at the top of low usable memory. The block therefore takes its base as that top, less both graphics stolen sizes, less the segment size. All sizes are held in 1 MB units. The base is recomputed combinationally whenever a size or the top value changes.

A request that is not allowed is not dropped. It still goes through, but its address is replaced by the fixed legacy location 0xC_0000. If it is a write, all of its byte enables are cleared, so the transaction finishes without touching memory. Every request leaves the block one clock after it enters, and the invalid flag comes out together with the rewritten request.

Configuration goes through a small synchronous write port. The selector codes are: 0 top of low memory, 1 graphics data stolen size, 2 graphics table stolen size, 3 segment size, 4 control. In the control word, bit 0 enables the segment and bit 1 enables the extended check on processor accesses. Size and top values are written in MB units.

Top module: `smram_guard`

## Requirements
- R1: During reset and after it, with no request presented, outValid and outInvalid are 0, and the segment and extended check are both disabled.
- R2: A request presented with reqValid in one cycle appears on the outputs, with outValid high, exactly one clock later. Exactly one output is produced per request, in order.
- R3: The lowest protected address is (top − data stolen − table stolen − segment size) × 1 MB. An address one byte below it is not in the segment; an address equal to it is.
- R4: The segment ends just below (top − data stolen − table stolen) × 1 MB. That address itself is outside the segment, and the byte below it is inside.
- R5: A processor request (agent code 0) with both the SMM and write-back attributes that hits the segment is forwarded with its own address and byte enables, and outInvalid is 0.
- R6: With the extended check enabled, a processor request that hits the segment is invalid if it lacks either the SMM attribute or the write-back attribute.
- R7: With the extended check disabled, a processor request that hits the segment is forwarded unchanged whatever its attributes.
- R8: A request from PCIe (code 1), DMI (code 2) or graphics (code 3) that hits the segment is invalid, even when it carries the SMM attribute.
- R9: An invalid request is output with address 0xC_0000 and outInvalid high. An invalid read keeps its byte enables.
- R10: An invalid write is output with all byte enables zero.
- R11: While the segment is disabled, no request is marked invalid and every request passes unchanged.
- R12: A configuration write takes effect for a request presented in the cycle after the write, and the base moves according to the new sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Configuration field selector (0 top, 1 data stolen, 2 table stolen, 3 segment size, 4 control) |
| cfgWrData | input | ADDR_W-MB_SHIFT | Configuration value in MB units, or control bits |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Request physical byte address |
| reqAgent | input | 2 | Originating agent: 0 processor, 1 PCIe, 2 DMI, 3 graphics |
| reqSmm | input | 1 | SMM attribute |
| reqWb | input | 1 | Write-back attribute |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqBe | input | BE_W | Byte enables |
| outValid | output | 1 | Forwarded request present |
| outAddr | output | ADDR_W | Address forwarded to DRAM |
| outBe | output | BE_W | Byte enables forwarded to DRAM |
| outWrite | output | 1 | Forwarded direction |
| outInvalid | output | 1 | Request was classified invalid and rewritten |

## Verification
Addresses are placed one byte either side of both segment edges. This separates an off-by-one error in the lower comparison from one in the upper comparison. Processor requests are sent with every attribute combination, once with the extended check off and once with it on. This shows whether the attribute test is gated by the control bit. Device requests carry the SMM attribute, which shows that the attribute does not excuse them. Reads and writes are both sent, so that address redirection and byte-enable stripping are told apart. A later size change, followed by a request just below the old base, confirms that the base really follows the configuration.

// File: rtl/smram_guard_pkg.sv
package smram_guard_pkg;
  typedef enum logic [1:0] {
    AG_CPU  = 2'd0,
    AG_PCIE = 2'd1,
    AG_DMI  = 2'd2,
    AG_GFX  = 2'd3
  } agent_e;

  typedef enum logic [2:0] {
    SEL_TOP  = 3'd0,
    SEL_DATA = 3'd1,
    SEL_GTT  = 3'd2,
    SEL_SEG  = 3'd3,
    SEL_CTRL = 3'd4
  } cfg_sel_e;

  // strobes from the decision logic to the forwarding stage
  typedef struct packed {
    logic load;
    logic redirect;
    logic stripBe;
  } fwd_strobe_t;
endpackage

// File: rtl/smram_guard_ctrl.sv
module smram_guard_ctrl
  import smram_guard_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MB_SHIFT = 20,
  localparam int MB_W    = ADDR_W - MB_SHIFT
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrEn,
  input  logic [2:0]      cfgSel,
  input  logic [MB_W-1:0] cfgWrData,
  input  logic            reqValid,
  input  logic [MB_W-1:0] reqAddrMb,
  input  logic [1:0]      reqAgent,
  input  logic            reqSmm,
  input  logic            reqWb,
  input  logic            reqWrite,
  output fwd_strobe_t     strobe
);
  logic [MB_W-1:0] topMb, dataMb, gttMb, segMb;
  logic            segEn, extEn;
  logic [MB_W-1:0] gfxBase, segBase;
  logic            inSeg, isCpu, cpuBad, badReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topMb  <= '0;
      dataMb <= '0;
      gttMb  <= '0;
      segMb  <= '0;
      segEn  <= 1'b0;
      extEn  <= 1'b0;
    end else if (cfgWrEn) begin
      case (cfg_sel_e'(cfgSel))
        SEL_TOP:  topMb  <= cfgWrData;
        SEL_DATA: dataMb <= cfgWrData;
        SEL_GTT:  gttMb  <= cfgWrData;
        SEL_SEG:  segMb  <= cfgWrData;
        SEL_CTRL: begin
          segEn <= cfgWrData[0];
          extEn <= cfgWrData[1];
        end
        default: ;
      endcase
    end
  end

  // base recomputed whenever any size or the top changes
  always_comb begin
    gfxBase = topMb - dataMb - gttMb;
    segBase = gfxBase - segMb;
    inSeg   = segEn && (reqAddrMb >= segBase) && (reqAddrMb < gfxBase);
    isCpu   = (reqAgent == AG_CPU);
    cpuBad  = extEn && (!reqSmm || !reqWb);
    badReq  = inSeg && (!isCpu || cpuBad);
    strobe.load     = reqValid;
    strobe.redirect = reqValid && badReq;
    strobe.stripBe  = reqValid && badReq && reqWrite;
  end
endmodule

// File: rtl/smram_guard_dp.sv
module smram_guard_dp
  import smram_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 8,
  parameter logic [ADDR_W-1:0] LEGACY_ADDR = ADDR_W'('h000C_0000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwd_strobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqBe,
  input  logic              reqWrite,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [BE_W-1:0]   outBe,
  output logic              outWrite,
  output logic              outInvalid
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outAddr    <= '0;
      outBe      <= '0;
      outWrite   <= 1'b0;
      outInvalid <= 1'b0;
    end else begin
      outValid   <= strobe.load;
      outInvalid <= strobe.redirect;
      if (strobe.load) begin
        outAddr  <= strobe.redirect ? LEGACY_ADDR : reqAddr;
        outBe    <= strobe.stripBe ? '0 : reqBe;
        outWrite <= reqWrite;
      end
    end
  end
endmodule

// File: rtl/smram_guard.sv
module smram_guard
  import smram_guard_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BE_W     = 8,
  parameter int MB_SHIFT = 20,
  parameter logic [ADDR_W-1:0] LEGACY_ADDR = ADDR_W'('h000C_0000),
  localparam int MB_W    = ADDR_W - MB_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [MB_W-1:0]   cfgWrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqAgent,
  input  logic              reqSmm,
  input  logic              reqWb,
  input  logic              reqWrite,
  input  logic [BE_W-1:0]   reqBe,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [BE_W-1:0]   outBe,
  output logic              outWrite,
  output logic              outInvalid
);
  fwd_strobe_t strobe;

  smram_guard_ctrl #(.ADDR_W(ADDR_W), .MB_SHIFT(MB_SHIFT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqAddrMb(reqAddr[ADDR_W-1:MB_SHIFT]),
    .reqAgent(reqAgent), .reqSmm(reqSmm), .reqWb(reqWb), .reqWrite(reqWrite),
    .strobe(strobe)
  );

  smram_guard_dp #(.ADDR_W(ADDR_W), .BE_W(BE_W), .LEGACY_ADDR(LEGACY_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqWrite(reqWrite),
    .outValid(outValid), .outAddr(outAddr), .outBe(outBe),
    .outWrite(outWrite), .outInvalid(outInvalid)
  );
endmodule

// File: rtl/smram_guard_chk.sv
module smram_guard_chk #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 8,
  parameter logic [ADDR_W-1:0] LEGACY_ADDR = ADDR_W'('h000C_0000)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqAgent,
  input logic              reqSmm,
  input logic              reqWb,
  input logic              reqWrite,
  input logic [BE_W-1:0]   reqBe,
  input logic              outValid,
  input logic [ADDR_W-1:0] outAddr,
  input logic [BE_W-1:0]   outBe,
  input logic              outWrite,
  input logic              outInvalid
);
  // R2
  req_to_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  // R2
  idle_no_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);
  // R5
  smm_cpu_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAgent == 2'd0 && reqSmm && reqWb)
      |=> (!outInvalid && outAddr == $past(reqAddr) && outBe == $past(reqBe)));
  // R9
  redirect_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outInvalid) |-> outAddr == LEGACY_ADDR);
  // R10
  write_strip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outInvalid && outWrite) |-> outBe == '0);
  // R1
  invalid_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outInvalid |-> outValid);
endmodule

bind smram_guard smram_guard_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W), .LEGACY_ADDR(LEGACY_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqAgent(reqAgent), .reqSmm(reqSmm), .reqWb(reqWb), .reqWrite(reqWrite),
  .reqBe(reqBe), .outValid(outValid), .outAddr(outAddr), .outBe(outBe),
  .outWrite(outWrite), .outInvalid(outInvalid)
);

// File: tb/smram_guard_bench.sv
`timescale 1ns/1ps
module smram_guard_bench;
  localparam int ADDR_W = 32;
  localparam int BE_W   = 8;
  localparam int MB_SH  = 20;
  localparam int MB_W   = ADDR_W - MB_SH;
  localparam logic [ADDR_W-1:0] LEGACY = 32'h000C_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgSel = '0;
  logic [MB_W-1:0] cfgWrData = '0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0] reqAgent = '0;
  logic reqSmm = 1'b0, reqWb = 1'b0, reqWrite = 1'b0;
  logic [BE_W-1:0] reqBe = '0;
  logic outValid, outWrite, outInvalid;
  logic [ADDR_W-1:0] outAddr;
  logic [BE_W-1:0] outBe;

  always #2.5 clk = ~clk;

  smram_guard u_smram_guard (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqAgent(reqAgent), .reqSmm(reqSmm),
    .reqWb(reqWb), .reqWrite(reqWrite), .reqBe(reqBe),
    .outValid(outValid), .outAddr(outAddr), .outBe(outBe),
    .outWrite(outWrite), .outInvalid(outInvalid)
  );

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BE_W-1:0]   be;
    logic              wr;
    logic              inv;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bench copies of configuration
  int topMb = 0, dataMb = 0, gttMb = 0, segMb = 0;
  bit segEn = 0, extEn = 0;

  task automatic cfg(input int sel, input int val);
    @(negedge clk);
    reqValid  = 1'b0;
    cfgWrEn   = 1'b1;
    cfgSel    = 3'(sel);
    cfgWrData = MB_W'(val);
    case (sel)
      0: topMb = val;
      1: dataMb = val;
      2: gttMb = val;
      3: segMb = val;
      default: begin segEn = val[0]; extEn = val[1]; end
    endcase
  endtask

  task automatic req(input string tag, input logic [ADDR_W-1:0] a, input int agent,
                     input bit smm, input bit wb, input bit wr, input logic [BE_W-1:0] be);
    exp_t e;
    int mb;
    bit hit, bad;
    @(negedge clk);
    cfgWrEn  = 1'b0;
    reqValid = 1'b1;
    reqAddr  = a;
    reqAgent = 2'(agent);
    reqSmm   = smm;
    reqWb    = wb;
    reqWrite = wr;
    reqBe    = be;
    mb  = int'(a >> MB_SH);
    hit = segEn && (mb >= topMb - dataMb - gttMb - segMb) && (mb < topMb - dataMb - gttMb);
    bad = hit && ((agent != 0) || (extEn && (!smm || !wb)));
    e.addr = bad ? LEGACY : a;
    e.be   = (bad && wr) ? '0 : be;
    e.wr   = wr;
    e.inv  = bad;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfgWrEn  = 1'b0;
      reqValid = 1'b0;
    end
  endtask

  function automatic logic [ADDR_W-1:0] mbAddr(input int mb);
    return ADDR_W'(mb) << MB_SH;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !finished && outValid) begin
      exp_t e;
      string t;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2: output with no pending request, actual valid=1 expected valid=0");
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (outAddr !== e.addr || outBe !== e.be || outWrite !== e.wr || outInvalid !== e.inv) begin
          errors++;
          $display("FAIL %s: actual addr=%h be=%h wr=%b inv=%b expected addr=%h be=%h wr=%b inv=%b",
                   t, outAddr, outBe, outWrite, outInvalid, e.addr, e.be, e.wr, e.inv);
        end
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    int seg0, gfx0;
    idle(3);
    // R1 reset state
    checks++;
    if (outValid !== 1'b0 || outInvalid !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual valid=%b inv=%b expected 0 0", outValid, outInvalid);
    end
    rstN = 1'b1;
    idle(2);
    checks++;
    if (outValid !== 1'b0 || outInvalid !== 1'b0) begin
      errors++;
      $display("FAIL R1: after reset actual valid=%b inv=%b expected 0 0", outValid, outInvalid);
    end
    // segment disabled by default: device hit passes (R1, R11)
    cfg(0, 2048); cfg(1, 64); cfg(2, 2); cfg(3, 8);
    gfx0 = 2048 - 64 - 2;
    seg0 = gfx0 - 8;
    req("R11", mbAddr(seg0 + 1), 1, 1'b0, 1'b0, 1'b1, 8'hFF);
    cfg(4, 1); // segment on, extended off
    req("R5", mbAddr(seg0 + 2) + 32'h40, 0, 1'b1, 1'b1, 1'b1, 8'h3C);
    req("R7", mbAddr(seg0 + 2), 0, 1'b0, 1'b0, 1'b0, 8'h0F);
    req("R7", mbAddr(seg0 + 3), 0, 1'b1, 1'b0, 1'b1, 8'hF0);
    cfg(4, 3); // extended on
    req("R6", mbAddr(seg0 + 4), 0, 1'b0, 1'b1, 1'b0, 8'hA5);
    req("R6", mbAddr(seg0 + 4), 0, 1'b1, 1'b0, 1'b1, 8'hFF);
    req("R5", mbAddr(seg0 + 5), 0, 1'b1, 1'b1, 1'b0, 8'h01);
    req("R10", mbAddr(seg0 + 1), 1, 1'b1, 1'b1, 1'b1, 8'hFF);
    req("R9", mbAddr(seg0 + 6), 2, 1'b0, 1'b1, 1'b0, 8'h77);
    req("R8", mbAddr(seg0 + 7), 3, 1'b1, 1'b1, 1'b0, 8'h81);
    req("R3", mbAddr(seg0) - 1, 1, 1'b0, 1'b0, 1'b1, 8'hFF);
    req("R3", mbAddr(seg0), 1, 1'b0, 1'b0, 1'b1, 8'hFF);
    req("R4", mbAddr(gfx0), 2, 1'b0, 1'b0, 1'b1, 8'h33);
    req("R4", mbAddr(gfx0) - 1, 2, 1'b0, 1'b0, 1'b1, 8'h33);
    req("R8", 32'h0000_1000, 1, 1'b0, 1'b0, 1'b1, 8'hFF); // low memory, no hit
    idle(2);
    cfg(4, 2); // segment off, extended on
    req("R11", mbAddr(seg0 + 1), 3, 1'b0, 1'b0, 1'b1, 8'hFF);
    req("R11", mbAddr(seg0 + 1), 0, 1'b0, 1'b0, 1'b1, 8'hFF);
    cfg(4, 3);
    cfg(3, 16); // base moves down 8 MB
    req("R12", mbAddr(seg0 - 4), 2, 1'b0, 1'b0, 1'b1, 8'hFF);
    req("R12", mbAddr(seg0 - 9), 2, 1'b0, 1'b0, 1'b1, 8'hFF);
    idle(3);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: actual pending=%0d expected 0", expQ.size());
    end
    summary();
  end
endmodule